// File: doc/BRIEF.md
# Vertical-Gradient Edge Binarizer

This block turns a raster stream of 8-bit grayscale pixels into a stream of one-bit edge flags. A frame opens with a pixel that carries the start flag; that pixel also latches the frame width and height. Two cascaded line buffers hold the previous two rows. Together with a short column shift they form a 3x3 neighbourhood around each centre pixel.

Only the vertical-gradient kernel is applied. It weights the row above by 1, 2, 1, ignores the centre row, and weights the row below by -1, -2, -1. The magnitude of that response is compared with a fixed threshold. Because no horizontal-gradient term is formed, only intensity changes between rows (edges that run across the picture) can produce a white output. Each output carries its own column and row coordinates. Border pixels are always reported as non-edge.

A small state machine sequences each frame:
- IDLE waits for a start pixel.
- FILL accepts the first row and the first pixel of the second row without producing any output.
- STREAM produces one result for every accepted pixel.
- FLUSH produces the final width-plus-one results on consecutive cycles, then returns to IDLE.

The transitions are:
- start-pixel (any state to FILL)
- row-one-reached (FILL to STREAM, on accepting pixel (0,1))
- last-pixel (STREAM to FLUSH)
- flush-done (FLUSH to IDLE, when the bottom-right result leaves)

Top module: `vge_edge_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, edge_valid, edge_bit, edge_x and edge_y are all zero.
- R2: A frame starts only on a cycle with pix_valid and pix_sof both high; that pixel is (0,0), and frame_width/frame_height are latched then. Pixels with pix_valid high but pix_sof low while idle produce no output.
- R3: A complete frame of width W and height H yields exactly W*H results, in raster order, with edge_x counting 0..W-1 within a row and edge_y counting 0..H-1.
- R4: The result for centre index k (k = y*W + x) appears on the outputs one clock after the input with index k+W+1 is accepted. The first W+1 accepted inputs of a frame produce no result.
- R5: The response is (a + 2b + c) of the row above minus (d + 2e + f) of the row below, over the left, centre and right columns. The centre row and any left-right intensity change have no influence.
- R6: A result is an edge (edge_bit = 1) only when the magnitude of the response is strictly greater than 120; a magnitude of exactly 120 gives 0.
- R7: Results on the first or last column or the first or last row of the frame always have edge_bit = 0.
- R8: Cycles with pix_valid low in the middle of a frame accept no pixel, produce no result and leave the neighbourhood unchanged, whatever pix_data holds.
- R9: After the last pixel of a frame, the remaining W+1 results come out on consecutive cycles without further input, and pix_valid without pix_sof is ignored during that time. The block is then idle.
- R10: A start pixel in the middle of a frame abandons that frame at once and begins a new one with the newly latched size.
- R11: Negative and positive responses of equal magnitude give the same decision (brighter-below and brighter-above edges are both detected).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pix_valid | input | 1 | Input pixel strobe |
| pix_sof | input | 1 | Marks the first pixel of a frame |
| pix_data | input | PIX_W | Grayscale pixel value |
| frame_width | input | WW | Pixels per row, latched at frame start (3..MAX_WIDTH) |
| frame_height | input | HW | Rows per frame, latched at frame start (3..MAX_HEIGHT) |
| edge_valid | output | 1 | Result strobe |
| edge_bit | output | 1 | 1 = edge (white), 0 = non-edge (black) |
| edge_x | output | WW | Column of the result |
| edge_y | output | HW | Row of the result |

## Verification
The following input patterns are used:
- Vertical stripes with no change between rows must give an all-black frame. This separates a pure vertical-gradient kernel from one that leaks horizontal gradients.
- Bright-above bands and bright-below bands separate a correct magnitude from a signed comparison.
- A ramp of exactly 15 levels per row gives a response of exactly 120, with a one-level bump that raises it to 121 and 122. This pins the strict threshold.
- Pseudo-random frames with stalls, garbage on the valid line during the flush, and a frame abandoned halfway stress the window alignment, the latency, the coordinate counters and the restart path.

// File: rtl/vge_pkg.sv
package vge_pkg;

    // rows in the convolution window; line buffers hold all but the newest row
    localparam int KERNEL_ROWS = 3;
    localparam int LINE_BUFS   = KERNEL_ROWS - 1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_STREAM,
        ST_FLUSH
    } vge_state_t;

endpackage

// File: rtl/vge_line_buf.sv
module vge_line_buf #(
    parameter int DEPTH = 640,
    parameter int DW    = 8,
    parameter int AW    = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    // read-before-write: the old row value is seen in the cycle it is replaced
    assign rdata = mem[addr];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

endmodule

// File: rtl/vge_gy_kernel.sv
module vge_gy_kernel #(
    parameter int PIX_W = 8,
    localparam int SUM_W = PIX_W + 2,
    localparam int GY_W  = PIX_W + 3
) (
    input  logic [PIX_W-1:0] top_l,
    input  logic [PIX_W-1:0] top_c,
    input  logic [PIX_W-1:0] top_r,
    input  logic [PIX_W-1:0] bot_l,
    input  logic [PIX_W-1:0] bot_c,
    input  logic [PIX_W-1:0] bot_r,
    output logic [SUM_W-1:0] mag
);

    logic [SUM_W-1:0]       top_sum;
    logic [SUM_W-1:0]       bot_sum;
    logic signed [GY_W-1:0] gy;
    logic signed [GY_W-1:0] gy_neg;

    always_comb begin
        top_sum = SUM_W'(top_l) + (SUM_W'(top_c) << 1) + SUM_W'(top_r);
        bot_sum = SUM_W'(bot_l) + (SUM_W'(bot_c) << 1) + SUM_W'(bot_r);
        gy      = $signed({1'b0, top_sum}) - $signed({1'b0, bot_sum});
        gy_neg  = -gy;
        mag     = gy[GY_W-1] ? gy_neg[SUM_W-1:0] : gy[SUM_W-1:0];
    end

endmodule

// File: rtl/vge_ctrl.sv
module vge_ctrl
    import vge_pkg::*;
#(
    parameter int WW = 10,
    parameter int HW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pix_valid,
    input  logic          pix_sof,
    input  logic [WW-1:0] frame_width,
    input  logic [HW-1:0] frame_height,
    output logic          take,
    output logic [WW-1:0] wr_x,
    output logic          emit,
    output logic [WW-1:0] out_x,
    output logic [HW-1:0] out_y,
    output logic          on_border,
    output logic [WW-1:0] cur_w,
    output logic [HW-1:0] cur_h,
    output vge_state_t    state
);

    localparam logic [WW-1:0] X_ONE = WW'(1);
    localparam logic [HW-1:0] Y_ONE = HW'(1);

    vge_state_t    state_nx;
    logic [WW-1:0] w_q;
    logic [HW-1:0] h_q;
    logic [WW-1:0] in_x;
    logic [HW-1:0] in_y;
    logic          start;
    logic [WW-1:0] eff_w;
    logic [HW-1:0] eff_h;
    logic [WW-1:0] cx;
    logic [HW-1:0] cy;
    logic          col_end;
    logic          row_end;
    logic          out_last;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next state and decoded strobes
    always_comb begin
        start    = pix_valid && pix_sof;
        eff_w    = start ? frame_width  : w_q;
        eff_h    = start ? frame_height : h_q;
        cx       = start ? '0 : in_x;
        cy       = start ? '0 : in_y;
        col_end  = (cx == eff_w - X_ONE);
        row_end  = (cy == eff_h - Y_ONE);
        out_last = (out_x == w_q - X_ONE) && (out_y == h_q - Y_ONE);
        take     = pix_valid && (start || state == ST_FILL || state == ST_STREAM);
        emit     = !start && ((state == ST_STREAM && pix_valid) || state == ST_FLUSH);
        wr_x     = cx;
        on_border = (out_x == '0) || (out_y == '0) ||
                    (out_x == w_q - X_ONE) || (out_y == h_q - Y_ONE);
        cur_w    = w_q;
        cur_h    = h_q;
        state_nx = state;
        if (start) begin
            state_nx = ST_FILL;
        end else begin
            unique case (state)
                ST_IDLE:   state_nx = ST_IDLE;
                ST_FILL:   if (take && cx == '0 && cy == Y_ONE) state_nx = ST_STREAM;
                ST_STREAM: if (take && col_end && row_end)      state_nx = ST_FLUSH;
                ST_FLUSH:  if (out_last)                        state_nx = ST_IDLE;
            endcase
        end
    end

    // input and output raster counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q   <= '0;
            h_q   <= '0;
            in_x  <= '0;
            in_y  <= '0;
            out_x <= '0;
            out_y <= '0;
        end else begin
            if (start) begin
                w_q   <= frame_width;
                h_q   <= frame_height;
                out_x <= '0;
                out_y <= '0;
            end
            if (take) begin
                in_x <= col_end ? '0 : cx + X_ONE;
                in_y <= col_end ? cy + Y_ONE : cy;
            end
            if (emit) begin
                if (out_x == w_q - X_ONE) begin
                    out_x <= '0;
                    out_y <= out_y + Y_ONE;
                end else begin
                    out_x <= out_x + X_ONE;
                end
            end
        end
    end

endmodule

// File: rtl/vge_edge_top.sv
module vge_edge_top
    import vge_pkg::*;
#(
    parameter int MAX_WIDTH  = 640,
    parameter int MAX_HEIGHT = 1023,
    parameter int PIX_W      = 8,
    parameter int THRESHOLD  = 120,
    localparam int WW    = $clog2(MAX_WIDTH + 1),
    localparam int HW    = $clog2(MAX_HEIGHT + 1),
    localparam int MAG_W = PIX_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_valid,
    input  logic             pix_sof,
    input  logic [PIX_W-1:0] pix_data,
    input  logic [WW-1:0]    frame_width,
    input  logic [HW-1:0]    frame_height,
    output logic             edge_valid,
    output logic             edge_bit,
    output logic [WW-1:0]    edge_x,
    output logic [HW-1:0]    edge_y
);

    localparam logic [MAG_W-1:0] THR_V = MAG_W'(THRESHOLD);

    logic             take;
    logic             emit;
    logic             on_border;
    logic [WW-1:0]    wr_x;
    logic [WW-1:0]    out_x;
    logic [HW-1:0]    out_y;
    logic [WW-1:0]    lat_w;
    logic [HW-1:0]    lat_h;
    vge_state_t       fsm_state;
    logic [MAG_W-1:0] mag;

    logic [PIX_W-1:0] lb_wdata [LINE_BUFS];
    logic [PIX_W-1:0] lb_rdata [LINE_BUFS];

    // only the outer rows carry weight, so only they need column history
    logic [PIX_W-1:0] top_d1, top_d2;
    logic [PIX_W-1:0] bot_d1, bot_d2;
    logic [PIX_W-1:0] top_now;

    vge_ctrl #(
        .WW (WW),
        .HW (HW)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .pix_valid    (pix_valid),
        .pix_sof      (pix_sof),
        .frame_width  (frame_width),
        .frame_height (frame_height),
        .take         (take),
        .wr_x         (wr_x),
        .emit         (emit),
        .out_x        (out_x),
        .out_y        (out_y),
        .on_border    (on_border),
        .cur_w        (lat_w),
        .cur_h        (lat_h),
        .state        (fsm_state)
    );

    for (genvar g = 0; g < LINE_BUFS; g++) begin : g_line
        if (g == 0) begin : g_head
            assign lb_wdata[g] = pix_data;
        end else begin : g_chain
            assign lb_wdata[g] = lb_rdata[g-1];
        end
        vge_line_buf #(
            .DEPTH (MAX_WIDTH),
            .DW    (PIX_W),
            .AW    (WW)
        ) u_lb (
            .clk   (clk),
            .we    (take),
            .addr  (wr_x),
            .wdata (lb_wdata[g]),
            .rdata (lb_rdata[g])
        );
    end

    assign top_now = lb_rdata[LINE_BUFS-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_d1 <= '0;
            top_d2 <= '0;
            bot_d1 <= '0;
            bot_d2 <= '0;
        end else if (take) begin
            top_d1 <= top_now;
            top_d2 <= top_d1;
            bot_d1 <= pix_data;
            bot_d2 <= bot_d1;
        end
    end

    vge_gy_kernel #(
        .PIX_W (PIX_W)
    ) u_kernel (
        .top_l (top_d2),
        .top_c (top_d1),
        .top_r (top_now),
        .bot_l (bot_d2),
        .bot_c (bot_d1),
        .bot_r (pix_data),
        .mag   (mag)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_valid <= 1'b0;
            edge_bit   <= 1'b0;
            edge_x     <= '0;
            edge_y     <= '0;
        end else begin
            edge_valid <= emit;
            if (emit) begin
                edge_x   <= out_x;
                edge_y   <= out_y;
                edge_bit <= !on_border && (mag > THR_V);
            end
        end
    end

endmodule

// File: rtl/vge_edge_checker.sv
module vge_edge_checker
    import vge_pkg::*;
#(
    parameter int WW = 10,
    parameter int HW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pix_valid,
    input logic          pix_sof,
    input logic          edge_valid,
    input logic          edge_bit,
    input logic [WW-1:0] edge_x,
    input logic [HW-1:0] edge_y,
    input vge_state_t    fsm_state,
    input logic [WW-1:0] lat_w,
    input logic [HW-1:0] lat_h
);

    logic [WW-1:0] last_x;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_x <= '0;
        end else if (edge_valid) begin
            last_x <= edge_x;
        end
    end

    // R7: first row and first column never white
    a_r7_border_first: assert property (@(posedge clk) disable iff (!rst_n)
        edge_valid && (edge_x == '0 || edge_y == '0) |-> !edge_bit);

    // R7: last row and last column never white
    a_r7_border_last: assert property (@(posedge clk) disable iff (!rst_n)
        edge_valid && (edge_x == lat_w - WW'(1) || edge_y == lat_h - HW'(1)) |-> !edge_bit);

    // R2: nothing is produced from the idle state
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_state == ST_IDLE |=> !edge_valid);

    // R4: the fill phase produces no result
    a_r4_fill_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_state == ST_FILL |=> !edge_valid);

    // R9: flush emits every cycle unless a new frame starts
    a_r9_flush_runs: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_state == ST_FLUSH && !(pix_valid && pix_sof) |=> edge_valid);

    // R3: columns advance by one within a row
    a_r3_raster_x: assert property (@(posedge clk) disable iff (!rst_n)
        edge_valid && edge_x != '0 |-> edge_x == last_x + WW'(1));

    // R3: coordinates stay inside the latched frame
    a_r3_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        edge_valid |-> (edge_x < lat_w) && (edge_y < lat_h));

endmodule

bind vge_edge_top vge_edge_checker #(
    .WW (WW),
    .HW (HW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pix_valid  (pix_valid),
    .pix_sof    (pix_sof),
    .edge_valid (edge_valid),
    .edge_bit   (edge_bit),
    .edge_x     (edge_x),
    .edge_y     (edge_y),
    .fsm_state  (fsm_state),
    .lat_w      (lat_w),
    .lat_h      (lat_h)
);

// File: tb/vge_edge_top_tb_top.sv
`timescale 1ns/1ps
module vge_edge_top_tb_top;

    localparam int WW  = 10;
    localparam int HW  = 10;
    localparam int THR = 120;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          pix_valid;
    logic          pix_sof;
    logic [7:0]    pix_data;
    logic [WW-1:0] frame_width;
    logic [HW-1:0] frame_height;
    logic          edge_valid;
    logic          edge_bit;
    logic [WW-1:0] edge_x;
    logic [HW-1:0] edge_y;

    always #10 clk = ~clk;

    vge_edge_top dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .pix_valid    (pix_valid),
        .pix_sof      (pix_sof),
        .pix_data     (pix_data),
        .frame_width  (frame_width),
        .frame_height (frame_height),
        .edge_valid   (edge_valid),
        .edge_bit     (edge_bit),
        .edge_x       (edge_x),
        .edge_y       (edge_y)
    );

    int    n_checks = 0;
    int    n_errors = 0;
    bit    done = 0;
    string cur_tag = "R1";

    // reference model state
    int img [0:4095];
    int m_st = 0;          // 0 idle, 1 accepting, 2 draining
    int m_n, m_k, mW, mH;
    int fw, fh;
    bit exp_valid = 0;
    bit exp_bit = 0;
    int exp_x = 0, exp_y = 0;
    int obs_cnt = 0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic fail(string tag, string what, int act, int expv);
        n_errors++;
        $display("FAIL %s %s: got %0d expected %0d", tag, what, act, expv);
    endtask

    function automatic int pix_of(int pat, int x, int y);
        case (pat)
            0: return (y < 3) ? 10 : 220;                          // dark above
            1: return (x % 2) ? 250 : 0;                           // vertical stripes
            2: return y * 15 + ((y == 3 && x == 3) ? 1 : 0);       // threshold ramp
            3: return (x * 37 + y * 91 + x * y * 13) & 255;        // pseudo-random
            default: return (y < 2) ? 255 : 0;                     // bright above
        endcase
    endfunction

    function automatic int gy_at(int x, int y);
        int t, b;
        t = img[(y-1)*mW + x-1] + 2*img[(y-1)*mW + x] + img[(y-1)*mW + x+1];
        b = img[(y+1)*mW + x-1] + 2*img[(y+1)*mW + x] + img[(y+1)*mW + x+1];
        return t - b;
    endfunction

    task automatic model_emit();
        int x, y, g;
        x = m_k % mW;
        y = m_k / mW;
        exp_valid = 1;
        exp_x = x;
        exp_y = y;
        if (x == 0 || y == 0 || x == mW-1 || y == mH-1) begin
            exp_bit = 0;
        end else begin
            g = gy_at(x, y);
            if (g < 0) g = -g;
            exp_bit = (g > THR);
        end
        m_k++;
    endtask

    task automatic model_step(bit v, bit s, int p);
        exp_valid = 0;
        if (v && s) begin
            mW = fw; mH = fh; m_n = 0; m_k = 0; m_st = 1;
            img[m_n] = p; m_n++;
        end else if (m_st == 1 && v) begin
            img[m_n] = p; m_n++;
            if (m_n - 1 >= mW + 1) model_emit();
            if (m_n == mW * mH) m_st = 2;
        end else if (m_st == 2) begin
            model_emit();
            if (m_k == mW * mH) m_st = 0;
        end
    endtask

    task automatic compare();
        n_checks++;
        if (edge_valid !== exp_valid) begin
            fail(cur_tag, "edge_valid (R4 timing)", int'(edge_valid), int'(exp_valid));
        end else if (exp_valid) begin
            obs_cnt++;
            if (int'(edge_x) != exp_x || int'(edge_y) != exp_y) begin
                fail("R3", "coordinate y*1000+x", int'(edge_y)*1000 + int'(edge_x),
                     exp_y*1000 + exp_x);
            end else if (edge_bit !== exp_bit) begin
                if (exp_x == 0 || exp_y == 0 || exp_x == mW-1 || exp_y == mH-1)
                    fail("R7", "border edge_bit", int'(edge_bit), int'(exp_bit));
                else
                    fail(cur_tag, "edge_bit", int'(edge_bit), int'(exp_bit));
            end
        end
    endtask

    task automatic cycle(bit v, bit s, int p);
        @(negedge clk);
        compare();
        pix_valid    = v;
        pix_sof      = s;
        pix_data     = p[7:0];
        frame_width  = WW'(fw);
        frame_height = HW'(fh);
        model_step(v, s, p);
    endtask

    // gaps: stall cycles inserted (R8); drain_valid: garbage on pix_valid while draining (R9)
    task automatic run_frame(int pat, int w, int h, bit gaps, bit drain_valid, int abort_at);
        fw = w; fh = h;
        for (int i = 0; i < w * h; i++) begin
            if (abort_at >= 0 && i == abort_at) return;
            if (gaps && i > 0) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                if (lfsr[1:0] == 2'b00) begin
                    cycle(0, 0, 8'h5A);
                    cycle(0, 0, 8'hFF);
                end
            end
            cycle(1, i == 0, pix_of(pat, i % w, i / w));
            if (i == 0) obs_cnt = 0;
        end
        for (int j = 0; j < w + 4; j++) cycle(drain_valid, 0, 8'hA5);
        n_checks++;
        if (obs_cnt != w * h) fail("R3", "results per frame", obs_cnt, w * h);
        n_checks++;
        if (edge_valid !== 1'b0) fail("R9", "idle after drain", int'(edge_valid), 0);
    endtask

    initial begin
        rst_n = 0; pix_valid = 0; pix_sof = 0; pix_data = 0;
        fw = 8; fh = 6;
        frame_width = WW'(fw); frame_height = HW'(fh);
        repeat (3) @(negedge clk);
        // R1: reset values
        n_checks++;
        if (edge_valid !== 1'b0 || edge_bit !== 1'b0 || edge_x !== '0 || edge_y !== '0)
            fail("R1", "outputs under reset", int'(edge_valid) + int'(edge_bit), 0);
        rst_n = 1;
        @(negedge clk);
        n_checks++;
        if (edge_valid !== 1'b0 || edge_bit !== 1'b0) fail("R1", "after reset", int'(edge_valid), 0);

        cur_tag = "R2";            // pixels without a start flag while idle
        for (int i = 0; i < 6; i++) cycle(1, 0, 200);
        for (int i = 0; i < 3; i++) cycle(0, 0, 0);

        cur_tag = "R5";            // stripes: no row change, must stay black
        run_frame(1, 8, 6, 0, 0, -1);
        run_frame(0, 8, 6, 0, 0, -1);

        cur_tag = "R4";            // exact latency on random data
        run_frame(3, 10, 5, 0, 0, -1);

        cur_tag = "R6";            // responses of 120, 121, 122
        run_frame(2, 9, 6, 0, 0, -1);

        cur_tag = "R11";           // bright above vs bright below
        run_frame(4, 7, 5, 0, 0, -1);

        cur_tag = "R8";            // stalls with junk data
        run_frame(3, 12, 7, 1, 0, -1);

        cur_tag = "R9";            // pix_valid high during drain
        run_frame(3, 6, 4, 0, 1, -1);

        cur_tag = "R10";           // abandon midway, restart with new size
        run_frame(3, 10, 6, 0, 0, 27);
        run_frame(0, 8, 5, 0, 0, -1);

        cur_tag = "R7";            // border on a minimal frame
        run_frame(3, 3, 3, 0, 0, -1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule